// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for 4 KiB pages in a small fully associative array. Each cached translation carries tags for the privilege regime it was loaded under, for the process that owns it (an address space identifier, unless the page is global) and for the guest that owns it (a virtual machine identifier, for guest-regime pages only). Because of these tags, translations for many processes, guests and privilege levels can sit in the array together. A context switch or a trap therefore does not force a flush.

A core presents the current page number, exception level, ASID and VMID on the lookup port and gets hit, physical page and entry index back in the same cycle. On a miss, an external table walker writes the result through the fill port. Maintenance logic removes stale translations with one of four invalidate commands. The top bit of the page number selects the upper or lower half of the virtual range, and it takes part in every tag compare.

Top module: `tlb_tagged`

## Requirements
- R1: After synchronous active-low reset every entry is invalid and no lookup hits.
- R2: Lookup is combinational. On a hit it returns the physical page and the index of the lowest-numbered matching entry. On a miss `lk_hit`, `lk_ppn` and `lk_idx` are all zero. A fill or invalidate changes lookup results from the next clock edge on.
- R3: An entry matches only the regime it was filled under. Levels 0 and 1 form one shared guest regime. Levels 2 and 3 are separate regimes of their own.
- R4: The ASID of a fill is bits [63:48] of `fill_tbr`. A non-global entry hits only for an equal current ASID. A global entry hits for any ASID.
- R5: A guest-regime entry hits only for an equal current VMID. Level 2 and level 3 entries ignore the VMID.
- R6: With `vmid_wide` = 0, only the low 8 VMID bits are stored at a fill and compared at a lookup. With `vmid_wide` = 1, all 16 bits are stored and compared.
- R7: The most significant page-number bit (upper or lower virtual range) is part of the tag. Pages that differ only in that bit never match each other.
- R8: A fill whose tags equal those of a valid entry (page, regime, global flag, ASID if non-global, VMID if guest) overwrites that entry in place. Any other fill goes to the entry under a round-robin pointer that starts at 0 and advances by one per such fill, wrapping after the last entry.
- R9: `inv_op` = 1 invalidates every entry.
- R10: `inv_op` = 2 invalidates the non-global entries whose ASID equals `inv_asid`. Guest entries are removed only if their VMID also equals `inv_vmid`.
- R11: `inv_op` = 3 invalidates all guest-regime entries whose VMID equals `inv_vmid`, global or not.
- R12: `inv_op` = 4 invalidates every entry whose page equals `inv_vpn` and whose regime is that of `inv_el`, whatever its ASID or VMID. `inv_op` = 0 does nothing.
- R13: When a fill and an invalidate fall in the same cycle, the invalidate is applied first. The fill then takes its slot against the surviving entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vmid_wide | input | 1 | 1: 16-bit VMID, 0: 8-bit VMID |
| lk_vpn | input | VPN_W | Lookup page number, MSB = upper range |
| lk_el | input | 2 | Current exception level |
| lk_asid | input | ASID_W | Current ASID |
| lk_vmid | input | VMID_W | Current VMID |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page on hit |
| lk_idx | output | IDX_W | Matching entry index |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | VPN_W | Page number to fill |
| fill_el | input | 2 | Level the walk was done for |
| fill_global | input | 1 | Translation is global (no ASID) |
| fill_tbr | input | 64 | Lower-range base register value, ASID in [63:48] |
| fill_vmid | input | VMID_W | VMID of the walk |
| fill_ppn | input | PPN_W | Physical page to store |
| inv_op | input | 3 | 0 none, 1 all, 2 by ASID, 3 by VMID, 4 by page |
| inv_asid | input | ASID_W | ASID for invalidate by ASID |
| inv_vmid | input | VMID_W | VMID for invalidate by ASID or VMID |
| inv_vpn | input | VPN_W | Page for invalidate by page |
| inv_el | input | 2 | Level for invalidate by page |

## Verification
The two functions that can meet in one cycle are a fill and an invalidate. The table walker may return a result while maintenance is removing translations. The bench issues both kinds together on purpose, including an invalidate-all next to a fill and a page invalidate aimed at the very entry the fill would otherwise overwrite in place. It also mixes them at random in a long run. The result is judged each cycle against a behavioural model that clears first and places the fill afterwards, by comparing hit, index and physical page at the lookup port.

// File: rtl/tlb_tag_pkg.sv
// Shared definitions for the tagged TLB: invalidate command codes and the
// mapping from exception level to translation regime.
// Assumes levels 0 and 1 share one regime (the guest regime).
package tlb_tag_pkg;

    typedef enum logic [2:0] {
        INV_NONE = 3'd0,
        INV_ALL  = 3'd1,
        INV_ASID = 3'd2,
        INV_VMID = 3'd3,
        INV_ADDR = 3'd4
    } inv_op_e;

    localparam logic [1:0] GUEST_REGIME = 2'd1;
    localparam int         VMID_NARROW  = 8;

    // Map an exception level to the regime it translates under.
    function automatic logic [1:0] regime_of(input logic [1:0] el);
        return (el == 2'd0) ? GUEST_REGIME : el;
    endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
// Tag comparator for one TLB entry. Answers whether a stored entry matches a
// query (page, regime, ASID, VMID) under the current VMID width.
// Assumes VMID_W >= 8; a global entry ignores the ASID, and a non-guest entry
// ignores the VMID.
module tlb_tag_cmp
    import tlb_tag_pkg::*;
#(
    parameter int VPN_W  = 36,
    parameter int ASID_W = 16,
    parameter int VMID_W = 16
) (
    input  logic              e_valid,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic [1:0]        e_regime,
    input  logic              e_global,
    input  logic [ASID_W-1:0] e_asid,
    input  logic [VMID_W-1:0] e_vmid,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [1:0]        q_regime,
    input  logic [ASID_W-1:0] q_asid,
    input  logic [VMID_W-1:0] q_vmid,
    input  logic              vmid_wide,
    output logic              match
);

    logic vmid_eq;
    logic vmid_ok;

    // VMID equality under the selected compare width.
    always_comb begin
        if (vmid_wide) vmid_eq = (e_vmid == q_vmid);
        else           vmid_eq = (e_vmid[VMID_NARROW-1:0] == q_vmid[VMID_NARROW-1:0]);
        vmid_ok = (e_regime != GUEST_REGIME) || vmid_eq;
    end

    // Combine all tag terms into one match.
    always_comb begin
        match = e_valid && (e_vpn == q_vpn) && (e_regime == q_regime)
                && (e_global || (e_asid == q_asid)) && vmid_ok;
    end

endmodule

// File: rtl/tlb_first_set.sv
// Priority encoder: reports whether any bit of a vector is set and the index
// of the lowest set bit. Assumes IDX_W is wide enough to hold N-1.
module tlb_first_set #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_tagged.sv
// Fully associative TLB whose entries are tagged with page, regime, ASID
// (unless global) and VMID (guest regime only). Lookup is combinational.
// Fills and invalidates update state on the clock edge, with the invalidate
// applied before the fill. Assumes 4 KiB pages and VMID_W >= 8.
module tlb_tagged
    import tlb_tag_pkg::*;
#(
    parameter int N      = 16,
    parameter int VPN_W  = 36,
    parameter int PPN_W  = 28,
    parameter int ASID_W = 16,
    parameter int VMID_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vmid_wide,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [1:0]        lk_el,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VMID_W-1:0] lk_vmid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [1:0]        fill_el,
    input  logic              fill_global,
    input  logic [63:0]       fill_tbr,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [2:0]        inv_op,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VMID_W-1:0] inv_vmid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [1:0]        inv_el
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [N-1:0]         valid_q;
    logic [N-1:0][1:0]    regime_q;
    logic [N-1:0]         glob_q;
    logic [VPN_W-1:0]     vpn_q  [N];
    logic [ASID_W-1:0]    asid_q [N];
    logic [VMID_W-1:0]    vmid_q [N];
    logic [PPN_W-1:0]     ppn_q  [N];
    logic [IDX_W-1:0]     rr_q;

    logic [N-1:0]         hit_vec;
    logic [N-1:0]         kill_vec;
    logic [N-1:0]         valid_post;
    logic [N-1:0]         same_vec;
    logic                 same_found;
    logic [IDX_W-1:0]     same_idx;
    logic [IDX_W-1:0]     target;
    logic [ASID_W-1:0]    fill_asid;
    logic [VMID_W-1:0]    fill_vmid_st;
    logic [1:0]           lk_regime;
    logic [1:0]           fill_regime;
    logic [1:0]           inv_regime;
    inv_op_e              op;
    logic                 unused_tbr_bits;

    // Decode the incoming fields into regimes, ASID and stored VMID.
    always_comb begin
        lk_regime       = regime_of(lk_el);
        fill_regime     = regime_of(fill_el);
        inv_regime      = regime_of(inv_el);
        fill_asid       = fill_tbr[63:64-ASID_W];
        unused_tbr_bits = ^fill_tbr[63-ASID_W:0];
        op              = inv_op_e'(inv_op);
        if (vmid_wide) fill_vmid_st = fill_vmid;
        else           fill_vmid_st = {{(VMID_W-VMID_NARROW){1'b0}}, fill_vmid[VMID_NARROW-1:0]};
    end

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic fill_tag_eq;
        logic vmid_inv_eq;

        tlb_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_lk_cmp (
            .e_valid(valid_q[i]), .e_vpn(vpn_q[i]), .e_regime(regime_q[i]),
            .e_global(glob_q[i]), .e_asid(asid_q[i]), .e_vmid(vmid_q[i]),
            .q_vpn(lk_vpn), .q_regime(lk_regime), .q_asid(lk_asid),
            .q_vmid(lk_vmid), .vmid_wide(vmid_wide), .match(hit_vec[i])
        );

        tlb_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_fill_cmp (
            .e_valid(valid_post[i]), .e_vpn(vpn_q[i]), .e_regime(regime_q[i]),
            .e_global(glob_q[i]), .e_asid(asid_q[i]), .e_vmid(vmid_q[i]),
            .q_vpn(fill_vpn), .q_regime(fill_regime), .q_asid(fill_asid),
            .q_vmid(fill_vmid_st), .vmid_wide(vmid_wide), .match(fill_tag_eq)
        );

        // Decide whether this entry is removed by the current invalidate.
        always_comb begin
            if (vmid_wide) vmid_inv_eq = (vmid_q[i] == inv_vmid);
            else           vmid_inv_eq = (vmid_q[i][VMID_NARROW-1:0] == inv_vmid[VMID_NARROW-1:0]);
            unique case (op)
                INV_ALL:  kill_vec[i] = 1'b1;
                INV_ASID: kill_vec[i] = !glob_q[i] && (asid_q[i] == inv_asid)
                                        && ((regime_q[i] != GUEST_REGIME) || vmid_inv_eq);
                INV_VMID: kill_vec[i] = (regime_q[i] == GUEST_REGIME) && vmid_inv_eq;
                INV_ADDR: kill_vec[i] = (vpn_q[i] == inv_vpn) && (regime_q[i] == inv_regime);
                default:  kill_vec[i] = 1'b0;
            endcase
            valid_post[i] = valid_q[i] && !kill_vec[i];
            same_vec[i]   = fill_tag_eq && (glob_q[i] == fill_global);
        end
    end

    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_hit_enc (
        .vec(hit_vec), .found(lk_hit), .idx(lk_idx)
    );

    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_same_enc (
        .vec(same_vec), .found(same_found), .idx(same_idx)
    );

    // Select the physical page of the winning entry and the fill slot.
    always_comb begin
        lk_ppn = lk_hit ? ppn_q[lk_idx] : '0;
        target = same_found ? same_idx : rr_q;
    end

    // Valid bits and replacement pointer: invalidate first, then fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            valid_q <= valid_post;
            if (fill_en) begin
                valid_q[target] <= 1'b1;
                if (!same_found) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // Entry payload and tags, written only by a fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            vpn_q[target]    <= fill_vpn;
            regime_q[target] <= fill_regime;
            glob_q[target]   <= fill_global;
            asid_q[target]   <= fill_asid;
            vmid_q[target]   <= fill_vmid_st;
            ppn_q[target]    <= fill_ppn;
        end
    end

endmodule

// File: rtl/tlb_tagged_chk.sv
// Property checker for tlb_tagged, attached by bind. Observes the lookup
// port, the command inputs and the valid and regime state of the entries.
module tlb_tagged_chk
    import tlb_tag_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        inv_op,
    input logic              fill_en,
    input logic              lk_hit,
    input logic [IDX_W-1:0]  lk_idx,
    input logic [1:0]        lk_el,
    input logic [N-1:0]      valid_q,
    input logic [N-1:0][1:0] regime_q
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0 && !lk_hit)); // R1

    AST_HIT_SAME_REGIME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q[lk_idx] && regime_q[lk_idx] == regime_of(lk_el))); // R3

    AST_FILL_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q != '0)); // R8

    AST_NO_SILENT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_op == 3'(INV_NONE)) |=> ($countones(valid_q) >= $countones($past(valid_q)))); // R8

    AST_INV_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_op == 3'(INV_ALL) && !fill_en) |=> (valid_q == '0)); // R9

    AST_INV_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_op == 3'(INV_ALL) && fill_en) |=> ($countones(valid_q) == 1)); // R13

endmodule

bind tlb_tagged tlb_tagged_chk #(.N(N), .IDX_W(IDX_W)) u_tlb_tagged_chk (
    .clk(clk), .rst_n(rst_n), .inv_op(inv_op), .fill_en(fill_en),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_el(lk_el),
    .valid_q(valid_q), .regime_q(regime_q)
);

// File: tb/test_tlb_tagged.sv
// Bench for tlb_tagged: a behavioural model of the entry set is updated on
// every clock and its lookup answer is compared with the design's each cycle.
module test_tlb_tagged;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vmid_wide = 1'b1;
    logic [35:0] lk_vpn = '0;
    logic [1:0]  lk_el = '0;
    logic [15:0] lk_asid = '0, lk_vmid = '0;
    logic        lk_hit;
    logic [27:0] lk_ppn;
    logic [3:0]  lk_idx;
    logic        fill_en = 1'b0, fill_global = 1'b0;
    logic [35:0] fill_vpn = '0;
    logic [1:0]  fill_el = '0;
    logic [63:0] fill_tbr = '0;
    logic [15:0] fill_vmid = '0;
    logic [27:0] fill_ppn = '0;
    logic [2:0]  inv_op = '0;
    logic [15:0] inv_asid = '0, inv_vmid = '0;
    logic [35:0] inv_vpn = '0;
    logic [1:0]  inv_el = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Model state
    bit          m_v [16];
    logic [35:0] m_vpn [16];
    int          m_reg [16];
    bit          m_g [16];
    logic [15:0] m_asid [16];
    logic [15:0] m_vmid [16];
    logic [27:0] m_ppn [16];
    int          m_rr = 0;

    tlb_tagged i_tlb_tagged (
        .clk(clk), .rst_n(rst_n), .vmid_wide(vmid_wide),
        .lk_vpn(lk_vpn), .lk_el(lk_el), .lk_asid(lk_asid), .lk_vmid(lk_vmid),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_idx(lk_idx),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_el(fill_el),
        .fill_global(fill_global), .fill_tbr(fill_tbr), .fill_vmid(fill_vmid),
        .fill_ppn(fill_ppn), .inv_op(inv_op), .inv_asid(inv_asid),
        .inv_vmid(inv_vmid), .inv_vpn(inv_vpn), .inv_el(inv_el)
    );

    always #5 clk = ~clk;

    function automatic int reg_of(input logic [1:0] el);
        return (el < 2) ? 1 : int'(el);
    endfunction

    function automatic bit veq(input logic [15:0] a, input logic [15:0] b);
        return vmid_wide ? (a == b) : (a[7:0] == b[7:0]);
    endfunction

    function automatic bit m_hits(input int i, input logic [35:0] vpn, input int rg,
                                  input logic [15:0] asid, input logic [15:0] vmid);
        return m_v[i] && m_vpn[i] == vpn && m_reg[i] == rg
               && (m_g[i] || m_asid[i] == asid) && (rg != 1 || veq(m_vmid[i], vmid));
    endfunction

    // Apply one clock of commands to the model: clear first, then place fill.
    task automatic model_update();
        int slot;
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_rr = 0;
            return;
        end
        for (int i = 0; i < 16; i++) begin
            case (inv_op)
                3'd1: m_v[i] = 0;
                3'd2: if (!m_g[i] && m_asid[i] == inv_asid && (m_reg[i] != 1 || veq(m_vmid[i], inv_vmid))) m_v[i] = 0;
                3'd3: if (m_reg[i] == 1 && veq(m_vmid[i], inv_vmid)) m_v[i] = 0;
                3'd4: if (m_vpn[i] == inv_vpn && m_reg[i] == reg_of(inv_el)) m_v[i] = 0;
                default: ;
            endcase
        end
        if (fill_en) begin
            logic [15:0] sv;
            sv = vmid_wide ? fill_vmid : {8'h00, fill_vmid[7:0]};
            slot = -1;
            for (int i = 15; i >= 0; i--)
                if (m_hits(i, fill_vpn, reg_of(fill_el), fill_tbr[63:48], sv) && m_g[i] == fill_global)
                    slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % 16;
            end
            m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_reg[slot] = reg_of(fill_el);
            m_g[slot] = fill_global; m_asid[slot] = fill_tbr[63:48];
            m_vmid[slot] = sv; m_ppn[slot] = fill_ppn;
        end
    endtask

    // Compare lookup port against the model, optionally check a directed hit
    // value, then advance one clock.
    task automatic step(input string req, input int exp);
        bit mh; int mi; logic [27:0] mp;
        #1;
        mh = 0; mi = 0; mp = '0;
        for (int i = 15; i >= 0; i--)
            if (m_hits(i, lk_vpn, reg_of(lk_el), lk_asid, lk_vmid)) begin
                mh = 1; mi = i; mp = m_ppn[i];
            end
        checks++;
        if (lk_hit !== mh || lk_idx !== 4'(mi) || lk_ppn !== mp) begin
            errors++;
            $display("FAIL %s: hit/idx/ppn actual %b/%0d/%h expected %b/%0d/%h",
                     req, lk_hit, lk_idx, lk_ppn, mh, mi, mp);
        end
        if (exp >= 0) begin
            checks++;
            if (lk_hit !== exp[0]) begin
                errors++;
                $display("FAIL %s: directed hit actual %b expected %0d", req, lk_hit, exp);
            end
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        fill_en = 0; inv_op = 3'd0;
    endtask

    task automatic lk(input logic [35:0] vpn, input logic [1:0] el,
                      input logic [15:0] asid, input logic [15:0] vmid);
        lk_vpn = vpn; lk_el = el; lk_asid = asid; lk_vmid = vmid;
    endtask

    task automatic fill(input logic [35:0] vpn, input logic [1:0] el, input bit g,
                        input logic [15:0] asid, input logic [15:0] vmid, input logic [27:0] ppn);
        fill_en = 1; fill_vpn = vpn; fill_el = el; fill_global = g;
        fill_tbr = {asid, 48'h0000_8765_4000}; fill_vmid = vmid; fill_ppn = ppn;
    endtask

    task automatic inv(input logic [2:0] op, input logic [15:0] asid, input logic [15:0] vmid,
                       input logic [35:0] vpn, input logic [1:0] el);
        inv_op = op; inv_asid = asid; inv_vmid = vmid; inv_vpn = vpn; inv_el = el;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: cycles actual %0d expected below 20000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        model_update();
        @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        lk(36'h100, 2'd1, 16'd5, 16'd3);
        step("R1", 0);

        // R2: fill then hit from next edge
        fill(36'h100, 2'd0, 0, 16'd5, 16'd3, 28'haaa);
        step("R2", 0);
        step("R2", 1);
        // R3: level 0 and 1 share; level 2 does not
        lk(36'h100, 2'd0, 16'd5, 16'd3); step("R3", 1);
        lk(36'h100, 2'd2, 16'd5, 16'd3); step("R3", 0);
        // R4: ASID mismatch misses
        lk(36'h100, 2'd1, 16'd6, 16'd3); step("R4", 0);
        // R5: VMID mismatch misses for guest
        lk(36'h100, 2'd1, 16'd5, 16'd4); step("R5", 0);
        // R5: level 2 ignores VMID
        fill(36'h200, 2'd2, 0, 16'd5, 16'd7, 28'hbbb); step("R5", -1);
        lk(36'h200, 2'd2, 16'd5, 16'd9); step("R5", 1);
        lk(36'h200, 2'd3, 16'd5, 16'd7); step("R3", 0);
        // R4: global matches any ASID, still needs VMID
        fill(36'h300, 2'd1, 1, 16'd1, 16'd3, 28'hccc); step("R4", -1);
        lk(36'h300, 2'd1, 16'd9, 16'd3); step("R4", 1);
        lk(36'h300, 2'd1, 16'd9, 16'd4); step("R5", 0);
        // R6: narrow VMID stores and compares low byte only
        vmid_wide = 0;
        fill(36'h400, 2'd1, 0, 16'd2, 16'h1203, 28'hddd); step("R6", -1);
        lk(36'h400, 2'd1, 16'd2, 16'h5503); step("R6", 1);
        vmid_wide = 1;
        lk(36'h400, 2'd1, 16'd2, 16'h0003); step("R6", 1);
        lk(36'h400, 2'd1, 16'd2, 16'h1203); step("R6", 0);
        // R7: range bit is part of the tag
        lk(36'h8_0000_0100, 2'd1, 16'd5, 16'd3); step("R7", 0);
        fill(36'h8_0000_0100, 2'd1, 0, 16'd5, 16'd3, 28'heee); step("R7", -1);
        step("R7", 1);
        lk(36'h100, 2'd1, 16'd5, 16'd3); step("R7", 1);
        // R8: exact refill overwrites in place
        fill(36'h100, 2'd0, 0, 16'd5, 16'd3, 28'h123); step("R8", -1);
        step("R8", 1);
        // R8: round robin wrap evicts older entries
        for (int k = 0; k < 14; k++) begin
            fill(36'h1000 + 36'(k), 2'd1, 0, 16'd8, 16'd3, 28'(k + 16'h50));
            lk(36'h1000 + 36'(k), 2'd1, 16'd8, 16'd3);
            step("R8", -1);
        end
        lk(36'h100, 2'd1, 16'd5, 16'd3); step("R8", 0);
        lk(36'h1003, 2'd1, 16'd8, 16'd3); step("R8", 1);

        // R9: invalidate all
        inv(3'd1, 0, 0, 0, 0); step("R9", -1);
        lk(36'h1003, 2'd1, 16'd8, 16'd3); step("R9", 0);

        // R10: by ASID, non-global, VMID-qualified for guests
        fill(36'h10, 2'd1, 0, 16'd5, 16'd3, 28'h11); step("R10", -1);
        fill(36'h11, 2'd1, 0, 16'd5, 16'd4, 28'h12); step("R10", -1);
        fill(36'h12, 2'd1, 1, 16'd5, 16'd3, 28'h13); step("R10", -1);
        fill(36'h13, 2'd2, 0, 16'd5, 16'd0, 28'h14); step("R10", -1);
        inv(3'd2, 16'd5, 16'd3, 0, 0); step("R10", -1);
        lk(36'h10, 2'd1, 16'd5, 16'd3); step("R10", 0);
        lk(36'h11, 2'd1, 16'd5, 16'd4); step("R10", 1);
        lk(36'h12, 2'd1, 16'd5, 16'd3); step("R10", 1);
        lk(36'h13, 2'd2, 16'd5, 16'd0); step("R10", 0);
        // R11: by VMID, including global guest entries
        inv(3'd3, 0, 16'd3, 0, 0); step("R11", -1);
        lk(36'h12, 2'd1, 16'd5, 16'd3); step("R11", 0);
        lk(36'h11, 2'd1, 16'd5, 16'd4); step("R11", 1);
        // R12: by page and regime, any ASID
        fill(36'h11, 2'd1, 0, 16'd9, 16'd4, 28'h15); step("R12", -1);
        fill(36'h11, 2'd2, 0, 16'd9, 16'd4, 28'h16); step("R12", -1);
        inv(3'd4, 0, 0, 36'h11, 2'd0); step("R12", -1);
        lk(36'h11, 2'd1, 16'd9, 16'd4); step("R12", 0);
        lk(36'h11, 2'd2, 16'd9, 16'd4); step("R12", 1);
        // R13: invalidate all together with a fill keeps only the fill
        inv(3'd1, 0, 0, 0, 0);
        fill(36'h20, 2'd1, 0, 16'd1, 16'd1, 28'h21);
        lk(36'h11, 2'd2, 16'd9, 16'd4); step("R13", 1);
        step("R13", 0);
        lk(36'h20, 2'd1, 16'd1, 16'd1); step("R13", 1);
        // R13: page invalidate on the entry an exact fill would reuse
        inv(3'd4, 0, 0, 36'h20, 2'd1);
        fill(36'h20, 2'd1, 0, 16'd1, 16'd1, 28'h22); step("R13", -1);
        step("R13", 1);

        // R2: mixed random traffic against the model
        for (int k = 0; k < 600; k++) begin
            lk(36'h10 + 36'($urandom % 4) + ((($urandom % 4) == 0) ? 36'h8_0000_0000 : 36'h0),
               2'($urandom % 4), 16'($urandom % 3), (($urandom % 2) == 0) ? 16'h0003 : 16'h0103);
            if (($urandom % 10) < 4)
                fill(36'h10 + 36'($urandom % 4), 2'($urandom % 4), ($urandom % 4) == 0,
                     16'($urandom % 3), (($urandom % 2) == 0) ? 16'h0003 : 16'h0103, 28'($urandom));
            if (($urandom % 10) == 0)
                inv(3'($urandom % 5), 16'($urandom % 3), 16'h0003, 36'h10 + 36'($urandom % 4),
                    2'($urandom % 4));
            if (($urandom % 50) == 0) vmid_wide = ~vmid_wide;
            step("R2", -1);
        end
        summary();
    end

endmodule